// File: doc/BRIEF.md
# Audio Programmed-I/O Sample Port

This block is the host side of an audio converter when samples move by programmed I/O rather than by DMA. The host polls a read-only status byte. That byte tells it three things for each direction: whether the data port wants or holds a byte, and which channel and which half of the sample the next byte belongs to. It also reports a sticky sample-timing error and an interrupt flag. One data offset serves both directions. Host writes fill a playback holding frame, and host reads drain a capture holding frame.

On the converter side, a playback strobe takes one complete frame out of the holding register. A capture strobe loads a fresh left/right pair. If a strobe finds the holding register in the wrong state, the block records an underrun or an overrun. That sets the interrupt flag. A host write of any value to the status offset clears it. The flag reaches the interrupt pin only while the enable input is high. Each direction has its own format inputs: stereo or mono, and 16-bit or 8-bit. These inputs decide how many bytes make up a frame and in what order they are transferred.

Top module: `pio_audio_port`

## Requirements
- R1: A read at offset 2 returns the status byte with this layout: bit 0 interrupt, bit 1 playback ready, bit 2 playback left, bit 3 playback upper, bit 4 sample error, bit 5 capture ready, bit 6 capture left, bit 7 capture upper.
- R2: After reset, with both directions enabled and set to 16-bit stereo, the status byte reads 0x46 and the interrupt output is low.
- R3: In 16-bit stereo, the bytes of a frame go in this order: left low, left high, right low, right high. The left flag (1 = left or mono, 0 = right) and the upper flag (1 = high byte or 8-bit, 0 = low byte) show the next position and advance after every accepted byte.
- R4: In mono, the left flag stays 1. In 8-bit mode, the upper flag stays 1. An 8-bit byte occupies the high half of the sample and the low half is zero. Mono playback drives the same sample on both outputs. An 8-bit capture read returns the high half.
- R5: Playback ready falls to 0 once the last byte of a frame is written. While it is 0, data writes are ignored. A playback strobe then moves the whole frame to the playback outputs and ready returns to 1.
- R6: A capture strobe loads both channels and sets capture ready. Data reads return the bytes in the R3 order. Capture ready falls after the last byte. A read while it is 0 does not advance the position.
- R7: A playback strobe while playback ready is 1 is an underrun. It sets the error and interrupt bits and leaves the playback outputs unchanged.
- R8: A capture strobe while unread capture data remains is an overrun. It sets the error and interrupt bits, and the old data stays in place.
- R9: A host write of any value to offset 2 clears the interrupt and error bits. If a new underrun or overrun happens in the same cycle, the bits stay set.
- R10: The interrupt output equals the interrupt bit while the interrupt-enable input is 1, and stays 0 while it is 0.
- R11: Disabling a direction returns its position to the first byte and empties its holding frame. Strobes in a disabled direction have no effect.
- R12: A capture read that takes the last byte of a frame, in the same cycle as a capture strobe, is not an overrun. The new frame is loaded and capture ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (advances capture only at data offset) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational from address) |
| irq_en | input | 1 | Interrupt pin enable |
| play_en | input | 1 | Playback direction enable |
| play_stereo | input | 1 | Playback stereo (1) or mono (0) |
| play_wide | input | 1 | Playback 16-bit (1) or 8-bit (0) |
| play_tick | input | 1 | Converter playback sample strobe |
| play_l | output | 2*DATA_W | Left playback sample |
| play_r | output | 2*DATA_W | Right playback sample |
| cap_en | input | 1 | Capture direction enable |
| cap_stereo | input | 1 | Capture stereo (1) or mono (0) |
| cap_wide | input | 1 | Capture 16-bit (1) or 8-bit (0) |
| cap_tick | input | 1 | Converter capture sample strobe |
| cap_l | input | 2*DATA_W | Left capture sample |
| cap_r | input | 2*DATA_W | Right capture sample |
| irq | output | 1 | Interrupt output |

## Verification
Two collisions are provoked on purpose. In the first, a status write meant to clear the interrupt arrives on the same edge as a playback strobe that finds no frame. The bench expects both the error bit and the interrupt bit to read 1 afterwards. In the second, the host reads the final capture byte on the same edge as a new capture strobe. The bench expects no error, capture ready still at 1, and the next read to return the low byte of the new left sample.

// File: rtl/pio_audio_pkg.sv
package pio_audio_pkg;

   // Status byte; member order fixes bit positions (first member = bit 7).
   typedef struct packed {
      logic cap_upper;
      logic cap_left;
      logic cap_ready;
      logic smp_error;
      logic play_upper;
      logic play_left;
      logic play_ready;
      logic int_flag;
   } status_t;

   localparam int STATUS_BITS = $bits(status_t);

endpackage

// File: rtl/pio_audio_seq.sv
// Byte/channel position tracker for one transfer direction.
module pio_audio_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic stereo,
   input  logic wide,
   input  logic step,
   output logic rsel,
   output logic upper,
   output logic last
);

   logic hi_q;
   logic rsel_q;

   assign rsel  = rsel_q;
   assign upper = wide ? hi_q : 1'b1;
   assign last  = upper && (!stereo || rsel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= 1'b0;
         rsel_q <= 1'b0;
      end else if (!en) begin
         hi_q   <= 1'b0;
         rsel_q <= 1'b0;
      end else if (step) begin
         if (last) begin
            hi_q   <= 1'b0;
            rsel_q <= 1'b0;
         end else if (wide && !hi_q) begin
            hi_q <= 1'b1;
         end else begin
            hi_q   <= 1'b0;
            rsel_q <= 1'b1;
         end
      end
   end

   a_r11_seq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rsel_q && !hi_q));

   a_r3_seq_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && last) |=> (!rsel_q && !hi_q));

endmodule

// File: rtl/pio_audio_play.sv
// Playback holding frame: host bytes in, whole frame out on converter strobe.
module pio_audio_play #(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  stereo,
   input  logic                  wide,
   input  logic                  wr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  tick,
   output logic                  ready,
   output logic                  rsel,
   output logic                  upper,
   output logic [2*DATA_W-1:0]   out_l,
   output logic [2*DATA_W-1:0]   out_r,
   output logic                  underrun
);

   localparam int SAMPLE_W = 2 * DATA_W;
   localparam int NCH      = 2;

   logic                full_q;
   logic                accept;
   logic                last;
   logic [SAMPLE_W-1:0] asm_q [NCH];
   logic [SAMPLE_W-1:0] out_l_q, out_r_q;

   assign accept   = en && wr && !full_q;
   assign underrun = en && tick && !full_q;
   assign ready    = !full_q;

   pio_audio_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .stereo (stereo),
      .wide   (wide),
      .step   (accept),
      .rsel   (rsel),
      .upper  (upper),
      .last   (last)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic hit;
      assign hit = accept && (rsel == (ch == 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            asm_q[ch] <= '0;
         end else if (hit) begin
            if (upper) begin
               asm_q[ch][SAMPLE_W-1 -: DATA_W] <= wdata;
               if (!wide) asm_q[ch][DATA_W-1:0] <= '0;
            end else begin
               asm_q[ch][DATA_W-1:0] <= wdata;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         out_l_q <= '0;
         out_r_q <= '0;
      end else if (!en) begin
         full_q <= 1'b0;
      end else if (tick && full_q) begin
         out_l_q <= asm_q[0];
         out_r_q <= stereo ? asm_q[1] : asm_q[0];
         full_q  <= 1'b0;
      end else if (accept && last) begin
         full_q <= 1'b1;
      end
   end

   assign out_l = out_l_q;
   assign out_r = out_r_q;

   a_r5_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |=> ($stable(asm_q[0]) && $stable(asm_q[1])));

   a_r7_outputs_kept: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> ($stable(out_l_q) && $stable(out_r_q)));

   a_r11_play_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ready);

endmodule

// File: rtl/pio_audio_cap.sv
// Capture holding frame: converter strobe loads, host reads drain byte-wise.
module pio_audio_cap #(
   parameter int DATA_W       = 8,
   parameter bit OVERRUN_KEEP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  stereo,
   input  logic                  wide,
   input  logic                  rd,
   input  logic                  tick,
   input  logic [2*DATA_W-1:0]   in_l,
   input  logic [2*DATA_W-1:0]   in_r,
   output logic                  ready,
   output logic                  rsel,
   output logic                  upper,
   output logic [DATA_W-1:0]     rbyte,
   output logic                  overrun
);

   localparam int SAMPLE_W = 2 * DATA_W;

   logic                full_q;
   logic                take;
   logic                last;
   logic                done;
   logic                load;
   logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
   logic [SAMPLE_W-1:0] word;

   assign take    = en && rd && full_q;
   assign done    = take && last;
   assign overrun = en && tick && full_q && !done;
   assign ready   = full_q;

   pio_audio_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .stereo (stereo),
      .wide   (wide),
      .step   (take),
      .rsel   (rsel),
      .upper  (upper),
      .last   (last)
   );

   if (OVERRUN_KEEP) begin : g_keep_old
      assign load = en && tick && (!full_q || done);

      a_r8_old_kept: assert property (@(posedge clk) disable iff (!rst_n)
         overrun |=> ($stable(hold_l_q) && $stable(hold_r_q)));
   end else begin : g_take_new
      assign load = en && tick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         hold_l_q <= '0;
         hold_r_q <= '0;
      end else if (!en) begin
         full_q <= 1'b0;
      end else if (load) begin
         hold_l_q <= in_l;
         hold_r_q <= in_r;
         full_q   <= 1'b1;
      end else if (done) begin
         full_q <= 1'b0;
      end
   end

   assign word  = rsel ? hold_r_q : hold_l_q;
   assign rbyte = upper ? word[SAMPLE_W-1 -: DATA_W] : word[DATA_W-1:0];

   a_r12_boundary_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tick) |=> ready);

   a_r6_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
      (en && full_q && !rd) |=> ready);

endmodule

// File: rtl/pio_audio_port.sv
// Programmed-I/O audio port: status byte, shared data offset, error/interrupt.
module pio_audio_port #(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 2,
   parameter int STATUS_OFS   = 2,
   parameter int DATA_OFS     = 3,
   parameter bit OVERRUN_KEEP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic                  host_wr,
   input  logic                  host_rd,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic [DATA_W-1:0]     host_rdata,
   input  logic                  irq_en,
   input  logic                  play_en,
   input  logic                  play_stereo,
   input  logic                  play_wide,
   input  logic                  play_tick,
   output logic [2*DATA_W-1:0]   play_l,
   output logic [2*DATA_W-1:0]   play_r,
   input  logic                  cap_en,
   input  logic                  cap_stereo,
   input  logic                  cap_wide,
   input  logic                  cap_tick,
   input  logic [2*DATA_W-1:0]   cap_l,
   input  logic [2*DATA_W-1:0]   cap_r,
   output logic                  irq
);
   import pio_audio_pkg::*;

   localparam int NOFS = 1 << ADDR_W;

   if (DATA_W < STATUS_BITS) begin : g_chk_width
      $error("DATA_W must hold the status byte");
   end
   if (STATUS_OFS == DATA_OFS) begin : g_chk_ofs
      $error("status and data offsets must differ");
   end
   if (STATUS_OFS >= NOFS || DATA_OFS >= NOFS) begin : g_chk_range
      $error("offsets must fit ADDR_W");
   end

   logic sel_stat, sel_data;
   logic stat_wr;
   logic play_rdy, play_rsel, play_upper, underrun;
   logic cap_rdy, cap_rsel, cap_upper, overrun;
   logic [DATA_W-1:0] cap_byte;
   logic int_q, err_q;
   status_t stat;

   assign sel_stat = (host_addr == ADDR_W'(STATUS_OFS));
   assign sel_data = (host_addr == ADDR_W'(DATA_OFS));
   assign stat_wr  = host_wr && sel_stat;

   pio_audio_play #(.DATA_W(DATA_W)) u_play (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (play_en),
      .stereo   (play_stereo),
      .wide     (play_wide),
      .wr       (host_wr && sel_data),
      .wdata    (host_wdata),
      .tick     (play_tick),
      .ready    (play_rdy),
      .rsel     (play_rsel),
      .upper    (play_upper),
      .out_l    (play_l),
      .out_r    (play_r),
      .underrun (underrun)
   );

   pio_audio_cap #(.DATA_W(DATA_W), .OVERRUN_KEEP(OVERRUN_KEEP)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cap_en),
      .stereo  (cap_stereo),
      .wide    (cap_wide),
      .rd      (host_rd && sel_data),
      .tick    (cap_tick),
      .in_l    (cap_l),
      .in_r    (cap_r),
      .ready   (cap_rdy),
      .rsel    (cap_rsel),
      .upper   (cap_upper),
      .rbyte   (cap_byte),
      .overrun (overrun)
   );

   // Sticky error/interrupt; a new event outranks a same-cycle clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q <= 1'b0;
         err_q <= 1'b0;
      end else if (underrun || overrun) begin
         int_q <= 1'b1;
         err_q <= 1'b1;
      end else if (stat_wr) begin
         int_q <= 1'b0;
         err_q <= 1'b0;
      end
   end

   always_comb begin
      stat.cap_upper  = cap_upper;
      stat.cap_left   = !cap_rsel;
      stat.cap_ready  = cap_rdy;
      stat.smp_error  = err_q;
      stat.play_upper = play_upper;
      stat.play_left  = !play_rsel;
      stat.play_ready = play_rdy;
      stat.int_flag   = int_q;
   end

   always_comb begin
      if (sel_stat)      host_rdata = DATA_W'(stat);
      else if (sel_data) host_rdata = cap_byte;
      else               host_rdata = '0;
   end

   assign irq = int_q && irq_en;

   a_r7_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (play_en && play_tick && play_rdy) |=> (err_q && int_q));

   a_r8_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && cap_tick && cap_rdy && !host_rd) |=> (err_q && int_q));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !play_tick && !cap_tick) |=> (!int_q && !err_q));

   a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && play_en && play_tick && play_rdy) |=> int_q);

   a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

endmodule

// File: tb/test_pio_audio_port.sv
`timescale 1ns/1ps
module test_pio_audio_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = 8'h00;
   logic [7:0]  host_rdata;
   logic        irq_en = 1'b1;
   logic        play_en = 1'b1, play_stereo = 1'b1, play_wide = 1'b1, play_tick = 1'b0;
   logic [15:0] play_l, play_r;
   logic        cap_en = 1'b1, cap_stereo = 1'b1, cap_wide = 1'b1, cap_tick = 1'b0;
   logic [15:0] cap_l = 16'h0, cap_r = 16'h0;
   logic        irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pio_audio_port i_pio_audio_port (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_en(irq_en), .play_en(play_en), .play_stereo(play_stereo),
      .play_wide(play_wide), .play_tick(play_tick), .play_l(play_l),
      .play_r(play_r), .cap_en(cap_en), .cap_stereo(cap_stereo),
      .cap_wide(cap_wide), .cap_tick(cap_tick), .cap_l(cap_l), .cap_r(cap_r),
      .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd_stat(output logic [7:0] v);
      host_addr = 2'd2;
      #1 v = host_rdata;
   endtask

   task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd_byte(output logic [7:0] v);
      host_addr = 2'd3; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic ptick();
      play_tick = 1'b1;
      @(negedge clk);
      play_tick = 1'b0;
   endtask

   task automatic ctick(input logic [15:0] l, input logic [15:0] r);
      cap_l = l; cap_r = r; cap_tick = 1'b1;
      @(negedge clk);
      cap_tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] s;
      rd_stat(s);
      chk("R2 reset status / R1 layout", s, 8'h46);
      chk("R2 reset irq", irq, 1'b0);
   endtask

   task automatic t_play16();
      logic [7:0] s;
      for (int i = 0; i < 4; i++) begin
         rd_stat(s);
         chk("R3 play position flags", s[3:1], {i[0], (i < 2), 1'b1});
         wr_byte(2'd3, 8'(8'h11 * (i + 1)));
      end
      rd_stat(s);
      chk("R5 playback ready falls", s[3:1], 3'b010);
      wr_byte(2'd3, 8'hEE);
      rd_stat(s);
      chk("R5 write ignored, position kept", s[3:1], 3'b010);
      ptick();
      chk("R5 R3 play left", play_l, 16'h2211);
      chk("R5 R3 play right", play_r, 16'h4433);
      rd_stat(s);
      chk("R5 ready back, no error", {s[4], s[1]}, 2'b01);
   endtask

   task automatic t_underrun();
      logic [7:0] s;
      ptick();
      chk("R7 outputs unchanged", play_l, 16'h2211);
      rd_stat(s);
      chk("R7 error and int set", {s[4], s[0]}, 2'b11);
      chk("R10 irq follows int", irq, 1'b1);
      wr_byte(2'd2, 8'h5C);
      rd_stat(s);
      chk("R9 status write clears", {s[4], s[0]}, 2'b00);
      chk("R9 irq cleared", irq, 1'b0);
   endtask

   task automatic t_irq_gate();
      logic [7:0] s;
      irq_en = 1'b0;
      ptick();
      rd_stat(s);
      chk("R10 int bit with pin masked", s[0], 1'b1);
      chk("R10 pin masked", irq, 1'b0);
      irq_en = 1'b1;
      #1 chk("R10 pin after enable", irq, 1'b1);
      wr_byte(2'd2, 8'h00);
   endtask

   task automatic t_clear_collide();
      logic [7:0] s;
      host_addr = 2'd2; host_wdata = 8'hFF; host_wr = 1'b1; play_tick = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; play_tick = 1'b0;
      rd_stat(s);
      chk("R9 new error beats clear", {s[4], s[0]}, 2'b11);
      wr_byte(2'd2, 8'h00);
      rd_stat(s);
      chk("R9 later clear", s[0], 1'b0);
   endtask

   task automatic t_play_disable();
      logic [7:0] s;
      wr_byte(2'd3, 8'h01);
      wr_byte(2'd3, 8'h02);
      rd_stat(s);
      chk("R3 at right low", s[3:1], 3'b001);
      play_en = 1'b0;
      ptick();
      play_en = 1'b1;
      rd_stat(s);
      chk("R11 position restarted", s[3:1], 3'b011);
      chk("R11 disabled tick no error", s[4], 1'b0);
      chk("R11 outputs untouched", play_l, 16'h2211);
   endtask

   task automatic t_play_mono8();
      logic [7:0] s;
      play_stereo = 1'b0; play_wide = 1'b0;
      rd_stat(s);
      chk("R4 mono8 flags", s[3:1], 3'b111);
      wr_byte(2'd3, 8'h5A);
      rd_stat(s);
      chk("R4 one byte fills frame", s[3:1], 3'b110);
      ptick();
      chk("R4 mono8 left", play_l, 16'h5A00);
      chk("R4 mono8 right copy", play_r, 16'h5A00);
      play_stereo = 1'b1; play_wide = 1'b1;
   endtask

   task automatic t_cap16();
      logic [7:0] s, b;
      logic [7:0] exp [4] = '{8'h34, 8'h12, 8'hCD, 8'hAB};
      ctick(16'h1234, 16'hABCD);
      rd_stat(s);
      chk("R6 capture ready", s[7:5], 3'b011);
      for (int i = 0; i < 4; i++) begin
         rd_stat(s);
         chk("R3 capture position flags", s[7:6], {i[0], (i < 2)});
         rd_byte(b);
         chk("R6 capture byte", b, exp[i]);
      end
      rd_stat(s);
      chk("R6 ready falls", s[7:5], 3'b010);
      rd_byte(b);
      rd_stat(s);
      chk("R6 stale read no advance", s[7:5], 3'b010);
   endtask

   task automatic t_overrun();
      logic [7:0] s, b;
      ctick(16'h1111, 16'h2222);
      ctick(16'h3333, 16'h4444);
      rd_stat(s);
      chk("R8 overrun flags", {s[4], s[0]}, 2'b11);
      rd_byte(b);
      chk("R8 old data kept", b, 8'h11);
      for (int i = 0; i < 3; i++) rd_byte(b);
      chk("R8 old right kept", b, 8'h22);
      wr_byte(2'd2, 8'h00);
   endtask

   task automatic t_read_tick();
      logic [7:0] s, b;
      ctick(16'h5566, 16'h7788);
      for (int i = 0; i < 3; i++) rd_byte(b);
      chk("R6 third byte", b, 8'h88);
      cap_l = 16'h99AA; cap_r = 16'hBBCC; cap_tick = 1'b1;
      rd_byte(b);
      cap_tick = 1'b0;
      chk("R12 last byte of old frame", b, 8'h77);
      rd_stat(s);
      chk("R12 no overrun, ready", {s[4], s[5]}, 2'b01);
      rd_byte(b);
      chk("R12 new frame first byte", b, 8'hAA);
      for (int i = 0; i < 3; i++) rd_byte(b);
   endtask

   task automatic t_cap_mono8();
      logic [7:0] s, b;
      cap_stereo = 1'b0; cap_wide = 1'b0;
      ctick(16'h9876, 16'h0000);
      rd_stat(s);
      chk("R4 capture mono8 flags", s[7:5], 3'b111);
      rd_byte(b);
      chk("R4 capture 8-bit high half", b, 8'h98);
      rd_stat(s);
      chk("R4 single read drains", s[7:5], 3'b110);
      ctick(16'h1357, 16'h0000);
      cap_en = 1'b0;
      @(negedge clk);
      cap_en = 1'b1;
      rd_stat(s);
      chk("R11 capture disable empties", {s[5], s[4]}, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_play16();
      t_underrun();
      t_irq_gate();
      t_clear_collide();
      t_play_disable();
      t_play_mono8();
      t_cap16();
      t_overrun();
      t_read_tick();
      t_cap_mono8();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule